// File: doc/BRIEF.md
# Compressed Address Command Encoder

This block turns a read or write request for one of four slaves into the command bit string sent on a serial link. The string is handed to a transmitter, which adds the start bit and the check code. Each request gives a slave number, a 21-bit byte address, a transfer size of 1, 2 or 4 bytes, a direction flag and up to four data bytes. The block returns the packed bits and their count.

To keep commands short, the encoder holds the word address of the last request that completed without error. If a new request hits that same word, it uses a 2-bit opcode and carries only the byte offset. If it lands close to that word on the same slave, it carries a 9-bit signed distance. In every other case it carries the whole address. The transaction layer reports each outcome with one of two strobes: a success strobe makes the most recent request's address the new reference, and a failure strobe drops the reference. The failure strobe is also used for terminate and break events.

The transfer size is folded into the low address bits plus one size bit. This works because transfers are naturally aligned.

Top module: `compact_cmd_encoder`

## Requirements
- R1: Each request accepted with `reqValid` yields `outValid` for exactly one cycle on the next clock edge. `outBits` is right-aligned: the first bit to send sits at position `outLen-1`, and every bit above that is zero. The field order, first sent to last, is: slave (2 bits), opcode, read flag (1 = read, 0 = write), address field, size bit, then the write data.
- R2: After reset, and whenever no reference is held, the encoder uses the absolute form. That form is opcode 3'b100 followed by the full 21-bit address, giving 28 bits for a read.
- R3: If the held reference equals {slave, address with bits 1:0 cleared}, the encoder uses the same-word form. That form is opcode 2'b11 and a 2-bit field taken from the address bits 1:0.
- R4: If the reference is held for the same slave and is not the same word, and the request address minus the reference address lies in -256..255, the encoder uses the relative form. That form is opcode 3'b101 with the difference as a 9-bit two's-complement field.
- R5: The relative window is inclusive at both ends. A difference of 255 or -256 is relative; a difference of 256 or -257 is absolute. The difference is taken against the held address, whose bits 1:0 are zero.
- R6: A request to a slave other than the one in the reference uses the absolute form.
- R7: The `reqSize` code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is treated as 4 bytes. A 1-byte transfer sends size bit 0 and leaves the address field untouched. A 2-byte transfer clears field bit 0 and sends size bit 1. A 4-byte transfer forces field bits 1:0 to 01 and sends size bit 1.
- R8: A write appends its data bytes after the size bit: byte 0 (`reqData[7:0]`) first, then byte 1, and so on, each byte MSB first. The number of bytes matches the size. A read appends no data.
- R9: `histOk` makes {slave, word address} of the most recent request the reference. `histFail` drops the reference, and it wins if both strobes are high together. With neither strobe high, the reference keeps its value.
- R10: While reset is asserted and right after it, `outValid` is 0 and no reference is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqSlave | input | 2 | Target slave number |
| reqAddr | input | 21 | Byte address |
| reqSize | input | 2 | Size code (0:1, 1:2, 2/3:4 bytes) |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqData | input | 32 | Write data, byte 0 in bits 7:0 |
| histOk | input | 1 | Last request succeeded: keep its address as reference |
| histFail | input | 1 | Failure, terminate or break: drop the reference |
| outValid | output | 1 | Command ready |
| outBits | output | 60 | Packed command, right-aligned |
| outLen | output | 6 | Number of valid bits in `outBits` |

## Verification
A command is due exactly one edge after its request. A history strobe changes the form chosen by the next request, not by one already issued. The driver drives its inputs on falling edges and holds `reqValid` for one cycle. Before raising the strobe, it pushes the expected bit string and length into a queue. The monitor samples on the following falling edge, which is one rising edge after the request, and pops one expected item for every `outValid`. History strobes are sent only between requests, so the expected form depends only on the reference model's state at that moment.

// File: rtl/cmdenc_pkg.sv
package cmdenc_pkg;
  localparam int PKG_REL_W = 9;

  typedef enum logic [1:0] {
    FORM_ABS  = 2'd0,
    FORM_REL  = 2'd1,
    FORM_SAME = 2'd2
  } addrForm_e;

  typedef struct packed {
    logic                 load;
    addrForm_e            form;
    logic [PKG_REL_W-1:0] relOff;
  } encStrobe_t;
endpackage

// File: rtl/cmdenc_ctrl.sv
module cmdenc_ctrl
  import cmdenc_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqSlave,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              histOk,
  input  logic              histFail,
  output encStrobe_t        strobe
);
  localparam int KEY_W = ID_W + ADDR_W;

  logic             lastValid;
  logic [KEY_W-1:0] lastKey;
  logic             pendValid;
  logic [KEY_W-1:0] pendKey;

  logic [KEY_W-1:0]         reqKey;
  logic signed [ADDR_W:0]   diff;
  logic                     fits;
  logic                     isSame;
  logic                     isRel;

  assign reqKey = {reqSlave, reqAddr[ADDR_W-1:2], 2'b00};
  assign diff   = $signed({1'b0, reqAddr}) - $signed({1'b0, lastKey[ADDR_W-1:0]});
  // The difference fits in PKG_REL_W signed bits when its upper bits are all sign copies
  assign fits   = (&diff[ADDR_W:PKG_REL_W-1]) | ~(|diff[ADDR_W:PKG_REL_W-1]);
  assign isSame = lastValid && (lastKey == reqKey);
  assign isRel  = lastValid && (lastKey[KEY_W-1:ADDR_W] == reqSlave) && fits;

  always_comb begin
    strobe.load   = reqValid;
    strobe.relOff = diff[PKG_REL_W-1:0];
    if (isSame)      strobe.form = FORM_SAME;
    else if (isRel)  strobe.form = FORM_REL;
    else             strobe.form = FORM_ABS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastValid <= 1'b0;
      lastKey   <= '0;
      pendValid <= 1'b0;
      pendKey   <= '0;
    end else begin
      if (histFail) begin
        lastValid <= 1'b0;
      end else if (histOk && pendValid) begin
        lastValid <= 1'b1;
        lastKey   <= pendKey;
      end
      if (reqValid) begin
        pendValid <= 1'b1;
        pendKey   <= reqKey;
      end
    end
  end

  // R9: a failure strobe always leaves no reference
  a_r9_fail_drops: assert property (@(posedge clk) disable iff (!rstN)
    histFail |=> !lastValid);
  // R9: a success strobe with a pending request leaves a reference
  a_r9_ok_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && !histFail && pendValid) |=> lastValid);
  // R9: with no strobe the reference is unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!histOk && !histFail) |=> ($stable(lastValid) && $stable(lastKey)));
  // R3: the short form is only ever picked from a held reference
  a_r3_same_needs_ref: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.form == FORM_SAME) |-> lastValid);
endmodule

// File: rtl/cmdenc_datapath.sv
module cmdenc_datapath
  import cmdenc_pkg::*;
#(
  parameter int         ID_W       = 2,
  parameter int         ADDR_W     = 21,
  parameter int         DATA_BYTES = 4,
  parameter logic [2:0] OP_ABS     = 3'b100,
  parameter logic [2:0] OP_REL     = 3'b101,
  parameter logic [1:0] OP_SAME    = 2'b11,
  parameter int         MSG_W      = ID_W + 3 + 1 + ADDR_W + 1 + 8 * DATA_BYTES,
  parameter int         LEN_W      = $clog2(MSG_W + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  encStrobe_t              strobe,
  input  logic [ID_W-1:0]         reqSlave,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqSize,
  input  logic                    reqRead,
  input  logic [8*DATA_BYTES-1:0] reqData,
  output logic                    outValid,
  output logic [MSG_W-1:0]        outBits,
  output logic [LEN_W-1:0]        outLen
);
  logic [3:0]            nBytes;
  logic [DATA_BYTES-1:0] byteEn;
  logic [ADDR_W-1:0]     field;
  logic [LEN_W-1:0]      fieldLen;
  logic [2:0]            opVal;
  logic [LEN_W-1:0]      opLen;
  logic [MSG_W-1:0]      packNext;
  logic [LEN_W-1:0]      lenNext;

  always_comb begin
    case (reqSize)
      2'd0:    nBytes = 4'd1;
      2'd1:    nBytes = 4'd2;
      default: nBytes = 4'd4;
    endcase
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : gByteEn
    assign byteEn[g] = !reqRead && (4'(g) < nBytes);
  end

  function automatic logic [MSG_W-1:0] pushBits(input logic [MSG_W-1:0] acc,
                                                input logic [MSG_W-1:0] val,
                                                input logic [LEN_W-1:0] n);
    logic [MSG_W-1:0] mask;
    mask = (MSG_W'(1) << n) - MSG_W'(1);
    return (acc << n) | (val & mask);
  endfunction

  always_comb begin
    case (strobe.form)
      FORM_SAME: begin
        field    = ADDR_W'(reqAddr[1:0]);
        fieldLen = LEN_W'(2);
        opVal    = {1'b0, OP_SAME};
        opLen    = LEN_W'(2);
      end
      FORM_REL: begin
        field    = ADDR_W'(strobe.relOff);
        fieldLen = LEN_W'(PKG_REL_W);
        opVal    = OP_REL;
        opLen    = LEN_W'(3);
      end
      default: begin
        field    = reqAddr;
        fieldLen = LEN_W'(ADDR_W);
        opVal    = OP_ABS;
        opLen    = LEN_W'(3);
      end
    endcase
    if (nBytes == 4'd2) field[0] = 1'b0;
    if (nBytes == 4'd4) field[1:0] = 2'b01;
  end

  always_comb begin
    packNext = MSG_W'(reqSlave);
    lenNext  = LEN_W'(ID_W);
    packNext = pushBits(packNext, MSG_W'(opVal), opLen);
    lenNext  = lenNext + opLen;
    packNext = pushBits(packNext, MSG_W'(reqRead), LEN_W'(1));
    packNext = pushBits(packNext, MSG_W'(field), fieldLen);
    packNext = pushBits(packNext, MSG_W'(nBytes > 4'd1), LEN_W'(1));
    lenNext  = lenNext + fieldLen + LEN_W'(2);
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (byteEn[i]) begin
        packNext = pushBits(packNext, MSG_W'(reqData[8*i +: 8]), LEN_W'(8));
        lenNext  = lenNext + LEN_W'(8);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outBits  <= '0;
      outLen   <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outBits <= packNext;
        outLen  <= lenNext;
      end
    end
  end

  // R1: every request gives a command on the next edge
  a_r1_next_edge: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);
  // R1: no command without a request
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !outValid);
  // R1: a valid command length lies between the shortest and the longest form
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLen >= LEN_W'(8) && outLen <= LEN_W'(MSG_W)));
endmodule

// File: rtl/compact_cmd_encoder.sv
module compact_cmd_encoder
  import cmdenc_pkg::*;
#(
  parameter int         ID_W       = 2,
  parameter int         ADDR_W     = 21,
  parameter int         DATA_BYTES = 4,
  parameter logic [2:0] OP_ABS     = 3'b100,
  parameter logic [2:0] OP_REL     = 3'b101,
  parameter logic [1:0] OP_SAME    = 2'b11,
  parameter int         MSG_W      = ID_W + 3 + 1 + ADDR_W + 1 + 8 * DATA_BYTES,
  parameter int         LEN_W      = $clog2(MSG_W + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ID_W-1:0]         reqSlave,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqSize,
  input  logic                    reqRead,
  input  logic [8*DATA_BYTES-1:0] reqData,
  input  logic                    histOk,
  input  logic                    histFail,
  output logic                    outValid,
  output logic [MSG_W-1:0]        outBits,
  output logic [LEN_W-1:0]        outLen
);
  encStrobe_t strobe;

  cmdenc_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqSlave (reqSlave),
    .reqAddr  (reqAddr),
    .histOk   (histOk),
    .histFail (histFail),
    .strobe   (strobe)
  );

  cmdenc_datapath #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES),
    .OP_ABS(OP_ABS), .OP_REL(OP_REL), .OP_SAME(OP_SAME),
    .MSG_W(MSG_W), .LEN_W(LEN_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqSlave (reqSlave),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqRead  (reqRead),
    .reqData  (reqData),
    .outValid (outValid),
    .outBits  (outBits),
    .outLen   (outLen)
  );
endmodule

// File: tb/compact_cmd_encoder_tb_top.sv
`timescale 1ns/1ps
module compact_cmd_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSlave = '0;
  logic [20:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqRead = 1'b0;
  logic [31:0] reqData = '0;
  logic        histOk = 1'b0;
  logic        histFail = 1'b0;
  logic        outValid;
  logic [59:0] outBits;
  logic [5:0]  outLen;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  logic [59:0] expBits[$];
  int          expLen[$];
  string       expTag[$];

  // reference state
  bit          mValid = 1'b0;
  logic [22:0] mLast = '0;
  bit          mPendValid = 1'b0;
  logic [22:0] mPend = '0;

  always #2.5 clk = ~clk;

  compact_cmd_encoder dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSlave(reqSlave),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqRead(reqRead), .reqData(reqData),
    .histOk(histOk), .histFail(histFail),
    .outValid(outValid), .outBits(outBits), .outLen(outLen)
  );

  function automatic void push(ref logic [63:0] acc, ref int len,
                               input logic [63:0] v, input int n);
    acc = (acc << n) | (v & ((64'd1 << n) - 64'd1));
    len += n;
  endfunction

  task automatic sendReq(input logic [1:0] id, input logic [20:0] addr,
                         input logic [1:0] sz, input bit rd,
                         input logic [31:0] data, input string tag);
    int nb;
    logic [22:0] key;
    int diff;
    int form; // 0 abs, 1 rel, 2 same
    logic [20:0] f;
    int fLen;
    logic [63:0] acc;
    int len;
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    key = {id, addr[20:2], 2'b00};
    diff = int'(addr) - int'(mLast[20:0]);
    if (mValid && mLast == key) form = 2;
    else if (mValid && mLast[22:21] == id && diff >= -256 && diff <= 255) form = 1;
    else form = 0;
    if (form == 2) begin f = 21'(addr[1:0]); fLen = 2; end
    else if (form == 1) begin f = 21'(diff[8:0]); fLen = 9; end
    else begin f = addr; fLen = 21; end
    if (nb == 2) f[0] = 1'b0;
    if (nb == 4) f[1:0] = 2'b01;
    acc = '0; len = 0;
    push(acc, len, 64'(id), 2);
    if (form == 2) push(acc, len, 64'd3, 2);
    else if (form == 1) push(acc, len, 64'd5, 3);
    else push(acc, len, 64'd4, 3);
    push(acc, len, 64'(rd), 1);
    push(acc, len, 64'(f), fLen);
    push(acc, len, 64'(nb > 1), 1);
    if (!rd) for (int i = 0; i < nb; i++) push(acc, len, 64'(data[8*i +: 8]), 8);
    mPend = key; mPendValid = 1'b1;
    expBits.push_back(acc[59:0]); expLen.push_back(len); expTag.push_back(tag);
    @(negedge clk);
    reqSlave = id; reqAddr = addr; reqSize = sz; reqRead = rd; reqData = data;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic strobe(input bit ok, input bit fail);
    @(negedge clk);
    histOk = ok; histFail = fail;
    if (fail) mValid = 1'b0;
    else if (ok && mPendValid) begin mValid = 1'b1; mLast = mPend; end
    @(negedge clk);
    histOk = 1'b0; histFail = 1'b0;
  endtask

  // monitor: pops one expected item per produced command
  always @(negedge clk) begin
    if (rstN && outValid) begin
      testCnt++;
      if (expBits.size() == 0) begin
        failCnt++;
        $display("FAIL R1 unexpected command: bits=%h len=%0d expected none", outBits, outLen);
      end else begin
        logic [59:0] eb;
        int el;
        string et;
        eb = expBits.pop_front(); el = expLen.pop_front(); et = expTag.pop_front();
        if (outBits !== eb || int'(outLen) != el) begin
          failCnt++;
          $display("FAIL %s bits=%h len=%0d expected bits=%h len=%0d", et, outBits, outLen, eb, el);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testCnt++;
    if (outValid !== 1'b0) begin
      failCnt++;
      $display("FAIL R10 outValid during reset=%b expected 0", outValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    testCnt++;
    if (outValid !== 1'b0) begin
      failCnt++;
      $display("FAIL R10 outValid after reset=%b expected 0", outValid);
    end
    sendReq(2'd1, 21'h001000, 2'd2, 1'b1, 32'h0, "R2 absolute after reset");
    strobe(1'b1, 1'b0);
    sendReq(2'd1, 21'h001002, 2'd1, 1'b1, 32'h0, "R3 same word");
    strobe(1'b1, 1'b0);
    sendReq(2'd1, 21'h0010FF, 2'd0, 1'b1, 32'h0, "R5 relative +255");
    strobe(1'b1, 1'b0);
    sendReq(2'd1, 21'h000FFC, 2'd2, 1'b1, 32'h0, "R5 relative -256");
    strobe(1'b1, 1'b0);
    sendReq(2'd1, 21'h0010FC, 2'd2, 1'b1, 32'h0, "R5 absolute +256");
    strobe(1'b0, 1'b1);
    sendReq(2'd1, 21'h0010FC, 2'd0, 1'b1, 32'h0, "R9 absolute after fail");
    strobe(1'b1, 1'b0);
    sendReq(2'd2, 21'h0010FC, 2'd0, 1'b1, 32'h0, "R6 other slave");
    sendReq(2'd1, 21'h001100, 2'd2, 1'b0, 32'hA1B2C3D4, "R4 relative write");
    strobe(1'b1, 1'b0);
    sendReq(2'd1, 21'h001101, 2'd0, 1'b0, 32'h000000AB, "R8 same write 1 byte");
    sendReq(2'd1, 21'h001103, 2'd1, 1'b0, 32'h00005A3C, "R7 same write 2 bytes");
    sendReq(2'd1, 21'h000FFF, 2'd0, 1'b1, 32'h0, "R5 absolute -257");
    sendReq(2'd1, 21'h001104, 2'd3, 1'b1, 32'h0, "R7 reserved size as 4");
    sendReq(2'd0, 21'h1FFFFF, 2'd2, 1'b0, 32'hDEADBEEF, "R8 absolute 4-byte write");
    strobe(1'b1, 1'b0);
    sendReq(2'd0, 21'h1FFFFC, 2'd0, 1'b1, 32'h0, "R3 same after write");
    strobe(1'b1, 1'b1);
    sendReq(2'd0, 21'h1FFFFC, 2'd0, 1'b1, 32'h0, "R9 both strobes invalidate");
    strobe(1'b1, 1'b0);
    sendReq(2'd0, 21'h1FFF00, 2'd0, 1'b1, 32'h0, "R4 relative negative");
    repeat (4) @(negedge clk);
    testCnt++;
    if (expBits.size() != 0) begin
      failCnt++;
      $display("FAIL R1 %0d commands missing expected 0", expBits.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule